// File: doc/BRIEF.md
# Single-Bit Page ECC Outcome Resolver

After a page read, a Hamming-style page ECC engine leaves a status word and a parity word. This block turns them into one verdict: clean page, freshly erased page, uncorrectable page, error confined to the stored check bytes, or a single correctable data bit. For the correctable case it repairs the page buffer itself. It reads the faulty word through a synchronous memory port, flips the reported bit and writes the word back.

A controller pulses `start` for one cycle while it holds the status flags, the parity word and the bus-width flag steady. The block latches these inputs on that edge. `done` then pulses for one cycle when the verdict, the reported addresses and the correction count are ready. They stay on the outputs until the next accepted start.

The design has no stream interface. Every pin is a plain control, status or memory pin. The memory port does not apply back-pressure: read data must be valid on `mem_rdata` in the cycle after `mem_rd_en`, and the memory takes a write in the cycle `mem_wr_en` is high.

Top module: `ecc_verdict_unit`

## Requirements
- R1: After reset, `result`, `word_addr`, `bit_addr`, `corr_count`, `done`, `mem_rd_en` and `mem_wr_en` are all zero.
- R2: When `status[0]` (recoverable-error flag) is clear, the verdict is CLEAN (code 0) with count 0 and no memory access, whatever the other flags say. `done` is high in the cycle after the start edge.
- R3: With `status[0]` and `status[1]` (multiple-error flag) set, and with both parity fields all ones, the verdict is ERASED (code 1) with count 0.
- R4: With `status[0]` and `status[1]` set and any parity field not all ones, the verdict is UNCORRECTABLE (code 2) with count 0.
- R5: When `status[0]` and `status[2]` (check-byte error flag) are set and `status[1]` is clear, the verdict is CHECK_ONLY (code 3) with count 0 and no write. The multiple-error rules R3/R4 take priority over this rule.
- R6: In 16-bit mode (`bus16`=1) with only `status[0]` set, the block flips bit `parity[3:0]` of word `parity[15:4]`. The verdict is FIXED (code 4) and the count is 1.
- R7: In 8-bit mode with only `status[0]` set and a bit offset of 7 or less, the block flips that bit and leaves bits [15:8] of the stored word unchanged.
- R8: In 8-bit mode with only `status[0]` set and a bit offset above 7, the verdict is UNCORRECTABLE with count 0 and the buffer is not written.
- R9: A correction is one read cycle, then one write cycle of the flipped word to the same address. `done` rises in the cycle after the write, three cycles after the start edge.
- R10: A `start` pulse that arrives while a correction is in progress is ignored. It produces no extra `done` and does not change the reported outcome.
- R11: `word_addr` and `bit_addr` report `parity[15:4]` and `parity[3:0]` of the accepted request, whatever the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| status | input | 3 | [0] recoverable error, [1] multiple errors, [2] error in check bytes |
| parity | input | 16 | [15:4] word address, [3:0] bit offset |
| bus16 | input | 1 | 1 = 16-bit buffer words, 0 = 8-bit |
| mem_rd_en | output | 1 | Buffer read request |
| mem_wr_en | output | 1 | Buffer write request |
| mem_addr | output | 12 | Buffer word address |
| mem_wdata | output | 16 | Corrected word |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd_en` |
| result | output | 3 | Verdict code (0..4 as in R2-R6) |
| word_addr | output | 12 | Reported word address |
| bit_addr | output | 4 | Reported bit offset |
| corr_count | output | 1 | Number of bits corrected (0 or 1) |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong sequencer state shows up at the memory pins within one cycle. Examples are a write without a preceding read, a read never followed by a write, or a write to an address other than the one read. The pulse on `done` then arrives early, late or twice. A wrong verdict or a wrong flip mask only becomes visible when `done` pulses, at most three cycles after the start edge. There it appears as a wrong code or count, as a buffer word that differs from the stored word in more or fewer than one bit, or as a changed upper byte in 8-bit mode.

// File: rtl/ecc_res_pkg.sv
package ecc_res_pkg;
  typedef enum logic [2:0] {
    RES_CLEAN   = 3'd0,
    RES_ERASED  = 3'd1,
    RES_UNCORR  = 3'd2,
    RES_CHKONLY = 3'd3,
    RES_FIXED   = 3'd4
  } res_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WRITE = 2'd2
  } seq_t;

  // status flag positions
  localparam int FLG_RECOV = 0;
  localparam int FLG_MULTI = 1;
  localparam int FLG_CHK   = 2;
  localparam int FLG_W     = 3;
endpackage

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_res_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BOFS_W   = 4,
  parameter int NARROW_W = 8
) (
  input  logic [FLG_W-1:0]  flags,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BOFS_W-1:0] bofs,
  input  logic              wide,
  output res_t              verdict
);
  localparam int BOFS_EXT = 32 - BOFS_W;

  logic all_ones;
  logic narrow_oob;

  assign all_ones   = (&waddr) && (&bofs);
  assign narrow_oob = !wide && ({{BOFS_EXT{1'b0}}, bofs} >= NARROW_W);

  // priority: no error, multiple errors, check-byte error, range, fix
  always_comb begin
    if (!flags[FLG_RECOV])      verdict = RES_CLEAN;
    else if (flags[FLG_MULTI])  verdict = all_ones ? RES_ERASED : RES_UNCORR;
    else if (flags[FLG_CHK])    verdict = RES_CHKONLY;
    else if (narrow_oob)        verdict = RES_UNCORR;
    else                        verdict = RES_FIXED;
  end
endmodule

// File: rtl/ecc_flip_mask.sv
module ecc_flip_mask #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int BOFS_W   = 4
) (
  input  logic [BOFS_W-1:0] bofs,
  input  logic              wide,
  output logic [DATA_W-1:0] mask
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < NARROW_W) begin : g_low
      assign mask[i] = (bofs == BOFS_W'(i));
    end else begin : g_high
      assign mask[i] = wide && (bofs == BOFS_W'(i));
    end
  end
endmodule

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq
  import ecc_res_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BOFS_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  res_t              verdict,
  input  logic [ADDR_W-1:0] waddr_in,
  input  logic [BOFS_W-1:0] bofs_in,
  input  logic              wide_in,
  input  logic [DATA_W-1:0] mask,
  output logic [BOFS_W-1:0] bofs_q,
  output logic              wide_q,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output res_t              result,
  output logic [ADDR_W-1:0] word_addr,
  output logic              corr_count,
  output logic              done
);
  seq_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      result     <= RES_CLEAN;
      word_addr  <= '0;
      bofs_q     <= '0;
      wide_q     <= 1'b0;
      corr_count <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SQ_IDLE: if (start) begin
          result     <= verdict;
          word_addr  <= waddr_in;
          bofs_q     <= bofs_in;
          wide_q     <= wide_in;
          corr_count <= 1'b0;
          if (verdict == RES_FIXED) state <= SQ_READ;
          else                      done  <= 1'b1;
        end
        SQ_READ:  state <= SQ_WRITE;
        SQ_WRITE: begin
          state      <= SQ_IDLE;
          done       <= 1'b1;
          corr_count <= 1'b1;
        end
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  assign mem_rd_en = (state == SQ_READ);
  assign mem_wr_en = (state == SQ_WRITE);
  assign mem_addr  = word_addr;
  assign mem_wdata = mem_rdata ^ mask;

  a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));
  a_r9_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en);
  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (done && corr_count));
  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $stable(mem_addr));
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($countones(mem_wdata ^ mem_rdata) == 1));
  a_r8_count_only_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (done && corr_count) |-> (result == RES_FIXED));
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_en, mem_wr_en}));
endmodule

// File: rtl/ecc_verdict_unit.sv
module ecc_verdict_unit
  import ecc_res_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BOFS_W   = 4,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        status,
  input  logic [ADDR_W+BOFS_W-1:0] parity,
  input  logic              bus16,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [2:0]        result,
  output logic [ADDR_W-1:0] word_addr,
  output logic [BOFS_W-1:0] bit_addr,
  output logic              corr_count,
  output logic              done
);
  localparam int PAR_W = ADDR_W + BOFS_W;

  logic [ADDR_W-1:0] in_waddr;
  logic [BOFS_W-1:0] in_bofs;
  res_t              verdict;
  res_t              res_q;
  logic [BOFS_W-1:0] bofs_q;
  logic              wide_q;
  logic [DATA_W-1:0] mask;

  assign in_waddr = parity[PAR_W-1:BOFS_W];
  assign in_bofs  = parity[BOFS_W-1:0];

  ecc_classify #(.ADDR_W(ADDR_W), .BOFS_W(BOFS_W), .NARROW_W(NARROW_W)) u_cls (
    .flags(status), .waddr(in_waddr), .bofs(in_bofs), .wide(bus16), .verdict(verdict)
  );

  ecc_flip_mask #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .BOFS_W(BOFS_W)) u_mask (
    .bofs(bofs_q), .wide(wide_q), .mask(mask)
  );

  ecc_rmw_seq #(.ADDR_W(ADDR_W), .BOFS_W(BOFS_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .verdict(verdict),
    .waddr_in(in_waddr), .bofs_in(in_bofs), .wide_in(bus16), .mask(mask),
    .bofs_q(bofs_q), .wide_q(wide_q),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .result(res_q), .word_addr(word_addr), .corr_count(corr_count), .done(done)
  );

  assign result   = res_q;
  assign bit_addr = bofs_q;

  // R7: narrow-mode write keeps the upper bits of the read word
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !wide_q) |-> (mem_wdata[DATA_W-1:NARROW_W] == mem_rdata[DATA_W-1:NARROW_W]));
endmodule

// File: tb/ecc_verdict_unit_tb.sv
module ecc_verdict_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  status = '0;
  logic [15:0] parity = '0;
  logic        bus16 = 1'b1;
  logic        mem_rd_en, mem_wr_en;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [2:0]  result;
  logic [11:0] word_addr;
  logic [3:0]  bit_addr;
  logic        corr_count, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wr_seen = 0;
  bit finished = 1'b0;

  logic [15:0] mem [0:4095];

  typedef struct {
    logic [2:0]  res;
    logic [11:0] wa;
    logic [3:0]  bo;
    logic        cnt;
    int          lat;
    int          nwr;
    logic [15:0] word;
    int          issue;
    string       req;
  } exp_t;
  exp_t q[$];

  ecc_verdict_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .status(status), .parity(parity),
    .bus16(bus16), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .result(result),
    .word_addr(word_addr), .bit_addr(bit_addr), .corr_count(corr_count), .done(done)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr_en) wr_seen++;
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected done", 32'(done), 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(result == e.res, {e.req, " result"}, 32'(result), 32'(e.res));
          chk(corr_count == e.cnt, {e.req, " count"}, 32'(corr_count), 32'(e.cnt));
          chk(word_addr == e.wa && bit_addr == e.bo, "R11 addresses",
              {16'd0, word_addr, bit_addr}, {16'd0, e.wa, e.bo});
          chk(cyc == e.issue + e.lat, "R9 done latency", 32'(cyc - e.issue), 32'(e.lat));
          chk(wr_seen == e.nwr, {e.req, " write count"}, 32'(wr_seen), 32'(e.nwr));
          if (e.nwr != 0)
            chk(mem[e.wa] == e.word, {e.req, " buffer word"}, 32'(mem[e.wa]), 32'(e.word));
        end
        wr_seen = 0;
      end
    end
  end

  function automatic exp_t predict(input logic [2:0] st, input logic [11:0] wa,
                                   input logic [3:0] bo, input logic b16, input string req);
    exp_t e;
    logic [15:0] m;
    e.wa = wa; e.bo = bo; e.req = req; e.cnt = 1'b0; e.lat = 1; e.nwr = 0; e.word = '0;
    if (!st[0])                e.res = 3'd0;
    else if (st[1])            e.res = (&wa && &bo) ? 3'd1 : 3'd2;
    else if (st[2])            e.res = 3'd3;
    else if (!b16 && bo > 4'd7) e.res = 3'd2;
    else begin
      e.res = 3'd4; e.cnt = 1'b1; e.lat = 3; e.nwr = 1;
      m = 16'd1 << bo;
      e.word = mem[wa] ^ m;
    end
    return e;
  endfunction

  task automatic issue(input logic [2:0] st, input logic [11:0] wa, input logic [3:0] bo,
                       input logic b16, input string req);
    exp_t e;
    @(negedge clk);
    e = predict(st, wa, bo, b16, req);
    e.issue = cyc;
    q.push_back(e);
    status = st; parity = {wa, bo}; bus16 = b16; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'(i * 37) ^ 16'hA5C3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(result == 3'd0 && word_addr == 0 && bit_addr == 0 && !corr_count && !done
        && !mem_rd_en && !mem_wr_en, "R1 reset outputs",
        {16'd0, result, corr_count, done, mem_rd_en, mem_wr_en, 9'd0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(3'b000, 12'h321, 4'h5, 1'b1, "R2 clean");
    issue(3'b110, 12'hFFF, 4'hF, 1'b1, "R2 flags ignored");
    issue(3'b011, 12'hFFF, 4'hF, 1'b1, "R3 erased wide");
    issue(3'b011, 12'hFFF, 4'hF, 1'b0, "R3 erased narrow");
    issue(3'b011, 12'hFFF, 4'hE, 1'b1, "R4 multi bit field");
    issue(3'b011, 12'h7FF, 4'hF, 1'b1, "R4 multi word field");
    issue(3'b101, 12'h044, 4'h2, 1'b1, "R5 check bytes");
    issue(3'b111, 12'h044, 4'h2, 1'b1, "R5 priority uncorr");
    issue(3'b111, 12'hFFF, 4'hF, 1'b1, "R5 priority erased");
    issue(3'b001, 12'h123, 4'hF, 1'b1, "R6 fix top bit");
    issue(3'b001, 12'h000, 4'h0, 1'b1, "R6 fix word zero");
    issue(3'b001, 12'hFFF, 4'h9, 1'b1, "R6 fix last word");
    issue(3'b001, 12'h123, 4'hF, 1'b1, "R6 fix back");
    issue(3'b001, 12'h456, 4'h7, 1'b0, "R7 narrow bit7");
    issue(3'b001, 12'h457, 4'h3, 1'b0, "R7 narrow bit3");
    issue(3'b001, 12'h458, 4'h8, 1'b0, "R8 narrow bit8");
    issue(3'b001, 12'h459, 4'hF, 1'b0, "R8 narrow bit15");

    // R10: start held through a correction is ignored
    begin
      exp_t e;
      logic [15:0] other;
      other = mem[12'h0AA];
      @(negedge clk);
      e = predict(3'b001, 12'h200, 4'hB, 1'b1, "R10 busy start");
      e.issue = cyc;
      q.push_back(e);
      status = 3'b001; parity = {12'h200, 4'hB}; bus16 = 1'b1; start = 1'b1;
      @(negedge clk);
      status = 3'b000; parity = {12'h0AA, 4'h1};
      @(negedge clk);
      status = 3'b001;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      chk(q.size() == 0, "R10 queue drained", 32'(q.size()), 32'd0);
      chk(mem[12'h0AA] == other, "R10 other word untouched", 32'(mem[12'h0AA]), 32'(other));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule